// File: doc/BRIEF.md
# Infrared run-length receive sampler

This block takes an already demodulated infrared line, samples it once per fixed sample period and converts the waveform into a stream of bytes. Each byte describes one stretch of constant level. Bit 7 marks a pulse (carrier present) or a space, and bits 6:0 give the length of the stretch in sample periods. The bytes are queued in a receive FIFO, and a host drains the FIFO through a small register interface.

The host configures the block through a control register. That register holds the receive enable, the input polarity, the trigger-level select and a flush strobe. A 16-bit space limit ends a packet: when a space lasts that many periods, the block emits the final space byte and flags a packet end. It then waits for the next pulse. A write-one-to-clear status register, together with an enable mask, drives a single interrupt line.

Register map, 3-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read, write 1 to clear |
| 2 | interrupt enable | read/write |
| 3 | FIFO count | read |
| 4 | FIFO data | read pops |
| 5 | space limit high byte | read/write |
| 6 | space limit low byte | read/write |

Control register bits: bit 0 is the receive enable, bit 1 is the polarity invert, bit 2 is the trigger select, and bit 3 is the flush strobe.

Top module: `ir_rx_sampler`

## Requirements
- R1: After reset, control, status, interrupt enable and FIFO count read 0, the space limit reads 0xFFFF, and irq_o is low.
- R2: Each queued byte has bit 7 = 1 for a pulse and 0 for a space, and bits 6:0 = the run length in sample periods. Space samples seen before the first pulse produce no bytes. A run's byte is queued when the level changes.
- R3: A run reaching 127 periods queues a chunk of 0x7F (with its pulse flag) and keeps counting from zero. At the level change, the remaining periods are queued as a final chunk, and no chunk of length 0 is ever queued.
- R4: When a space reaches the space limit (high byte at address 5, low byte at address 6; values below 2 disable the check), the block queues that space's remaining length including the limiting sample. It then sets status bit 5 (packet end) and queues nothing more until the next pulse.
- R5: With control bit 1 set, a low input counts as a pulse and a high input as a space.
- R6: Status bit 7 (data ready) is set by every byte the encoder produces, bit 6 while the FIFO count is at or above the trigger level, bit 5 on a packet end, and bit 4 on overrun. Bits 3:0 read 0. Writing 1 to a bit clears it unless it is set again in the same cycle.
- R7: irq_o is high exactly when status and the interrupt enable register (address 2) share a set bit.
- R8: Address 3 returns the number of queued bytes. Each read of address 4 returns the oldest byte and removes it, in arrival order.
- R9: Control bit 2 selects the trigger level: 0 selects 8 entries and 1 selects 16.
- R10: The FIFO holds 32 bytes. A byte produced while the FIFO is full is dropped, the stored bytes are untouched, and status bits 4 and 7 are set.
- R11: Writing control with bit 3 set empties the FIFO, and the next count read is 0.
- R12: With control bit 0 clear, no bytes are queued and the encoder returns to waiting for a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared line, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe, pops FIFO at address 4 |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong run counter or level register in the encoder shows up on the data register. The corrupted byte appears on the first read after the next level change, which is at most one run later. A wrong FIFO count shows in the count register on the next read. It also causes a missing or spurious overrun or trigger flag as soon as the FIFO fills past the trigger level. A stuck idle flag shows as bytes queued while the line holds a space after a packet end, or as no bytes at all for pulses. A status bit that is not cleared or set correctly reaches irq_o in the same cycle.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_IEN    = 3'd2,
    A_CNT    = 3'd3,
    A_DATA   = 3'd4,
    A_LIM_HI = 3'd5,
    A_LIM_LO = 3'd6
  } reg_addr_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_INV   = 1;
  localparam int CTL_TRG   = 2;
  localparam int CTL_FLUSH = 3;

  // status bits 7..4 kept in a 4-bit register, bit order rdr, rtr, pe, ovr
  localparam int ST_RDR = 3;
  localparam int ST_RTR = 2;
  localparam int ST_PE  = 1;
  localparam int ST_OVR = 0;

  localparam logic [6:0] RUN_MAX = 7'h7F;
endpackage

// File: rtl/ir_rx_sync_tick.sv
module ir_rx_sync_tick #(
  parameter int unsigned CLK_DIV = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic lvl_o,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], ir_i};
      div_q  <= (div_q == CW'(CLK_DIV - 1)) ? '0 : div_q + 1'b1;
    end
  end

  assign lvl_o  = sync_q[1];
  assign tick_o = (div_q == CW'(CLK_DIV - 1));
endmodule

// File: rtl/ir_rx_run_enc.sv
module ir_rx_run_enc
  import ir_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tick_i,
  input  logic        lvl_i,
  input  logic [15:0] limit_i,
  output logic        push_o,
  output logic [7:0]  byte_o,
  output logic        pe_o
);
  logic        idle_q, cur_q;
  logic [6:0]  cnt_q;
  logic [15:0] spc_q;
  logic [6:0]  cnt_nxt;
  logic [15:0] spc_nxt;
  logic        limit_hit;

  always_comb begin
    cnt_nxt   = cnt_q + 7'd1;
    spc_nxt   = (spc_q == 16'hFFFF) ? spc_q : spc_q + 16'd1;
    limit_hit = !cur_q && (limit_i >= 16'd2) && (spc_nxt == limit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      cur_q  <= 1'b0;
      cnt_q  <= '0;
      spc_q  <= '0;
      push_o <= 1'b0;
      pe_o   <= 1'b0;
      byte_o <= '0;
    end else begin
      push_o <= 1'b0;
      pe_o   <= 1'b0;
      if (!en_i) begin
        idle_q <= 1'b1;
        cur_q  <= 1'b0;
        cnt_q  <= '0;
        spc_q  <= '0;
      end else if (tick_i) begin
        if (idle_q) begin
          if (lvl_i) begin
            idle_q <= 1'b0;
            cur_q  <= 1'b1;
            cnt_q  <= 7'd1;
          end
        end else if (lvl_i != cur_q) begin
          push_o <= (cnt_q != '0);
          byte_o <= {cur_q, cnt_q};
          cur_q  <= lvl_i;
          cnt_q  <= 7'd1;
          spc_q  <= 16'd1;
        end else begin
          if (!cur_q) spc_q <= spc_nxt;
          if (limit_hit) begin
            push_o <= 1'b1;
            pe_o   <= 1'b1;
            byte_o <= {1'b0, cnt_nxt};
            idle_q <= 1'b1;
            cnt_q  <= '0;
          end else if (cnt_nxt == RUN_MAX) begin
            push_o <= 1'b1;
            byte_o <= {cur_q, RUN_MAX};
            cnt_q  <= '0;
          end else begin
            cnt_q  <= cnt_nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_pop, do_push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty && !flush_i;
  assign do_push = push_i && (!full || do_pop) && !flush_i;
  assign drop_o  = push_i && full && !do_pop && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = empty ? '0 : mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
  import ir_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 5000,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned TRIG_LO    = 8,
  parameter int unsigned TRIG_HI    = 16,
  parameter logic [15:0] LIMIT_RST  = 16'hFFFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [2:0]       ctrl_q;
  logic [3:0]       stat_q, stat_set, stat_clr;
  logic [7:0]       ien_q;
  logic [15:0]      lim_q;
  logic             lvl_raw, tick;
  logic             enc_push, enc_pe;
  logic [7:0]       enc_byte, fifo_rdata;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_drop, flush, pop, trig_hit;

  ir_rx_sync_tick #(.CLK_DIV(CLK_DIV)) i_sync (
    .clk_i, .rst_ni, .ir_i,
    .lvl_o(lvl_raw), .tick_o(tick)
  );

  ir_rx_run_enc i_enc (
    .clk_i, .rst_ni,
    .en_i(ctrl_q[CTL_EN]),
    .tick_i(tick),
    .lvl_i(lvl_raw ^ ctrl_q[CTL_INV]),
    .limit_i(lim_q),
    .push_o(enc_push), .byte_o(enc_byte), .pe_o(enc_pe)
  );

  assign flush = reg_wr_i && (reg_addr_i == A_CTRL) && reg_wdata_i[CTL_FLUSH];
  assign pop   = reg_rd_i && (reg_addr_i == A_DATA);

  ir_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush),
    .push_i(enc_push), .wdata_i(enc_byte),
    .pop_i(pop), .rdata_o(fifo_rdata),
    .count_o(fifo_cnt), .drop_o(fifo_drop)
  );

  assign trig_hit = fifo_cnt >= (ctrl_q[CTL_TRG] ? CNT_W'(TRIG_HI) : CNT_W'(TRIG_LO));

  always_comb begin
    stat_set          = '0;
    stat_set[ST_RDR]  = enc_push;
    stat_set[ST_RTR]  = trig_hit;
    stat_set[ST_PE]   = enc_pe;
    stat_set[ST_OVR]  = fifo_drop;
    stat_clr = (reg_wr_i && (reg_addr_i == A_STAT)) ? reg_wdata_i[7:4] : 4'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      lim_q  <= LIMIT_RST;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CTRL:   ctrl_q       <= reg_wdata_i[2:0];
          A_IEN:    ien_q        <= reg_wdata_i;
          A_LIM_HI: lim_q[15:8]  <= reg_wdata_i;
          A_LIM_LO: lim_q[7:0]   <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {5'b0, ctrl_q};
      A_STAT:   reg_rdata_o = {stat_q, 4'b0};
      A_IEN:    reg_rdata_o = ien_q;
      A_CNT:    reg_rdata_o = 8'(fifo_cnt);
      A_DATA:   reg_rdata_o = fifo_rdata;
      A_LIM_HI: reg_rdata_o = lim_q[15:8];
      A_LIM_LO: reg_rdata_o = lim_q[7:0];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |({stat_q, 4'b0} & ien_q);
endmodule

// File: rtl/ir_rx_sampler_chk.sv
module ir_rx_sampler_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          push_i,
  input logic [7:0]    byte_i,
  input logic          pe_i,
  input logic          pop_i,
  input logic          flush_i,
  input logic [CW-1:0] count_i,
  input logic [3:0]    stat_i
);
  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  p_ovr_sets_rdr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[0]) |-> stat_i[3]);

  p_nonzero_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (byte_i[6:0] != 7'd0));

  p_pe_is_space_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_i |-> (push_i && !byte_i[7]));

  p_disabled_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !push_i);

  p_flush_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_i == '0));

  p_pop_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && count_i != '0) |=> (count_i == $past(count_i) - 1'b1));
endmodule

bind ir_rx_sampler ir_rx_sampler_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl_q[0]),
  .push_i(enc_push), .byte_i(enc_byte), .pe_i(enc_pe),
  .pop_i(pop), .flush_i(flush), .count_i(fifo_cnt), .stat_i(stat_q)
);

// File: tb/test_ir_rx_sampler.sv
module test_ir_rx_sampler;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ir_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  ir_rx_sampler #(.CLK_DIV(DIV)) i_ir_rx_sampler (
    .clk_i(clk), .rst_ni, .ir_i, .reg_wr_i, .reg_rd_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic seg(input logic lvl, input int n);
    ir_i = lvl;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic clean();
    wr(3'd0, 8'h08);
    wr(3'd1, 8'hFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 3'd0, 8'h00);
    rd_chk("R1 status", 3'd1, 8'h00);
    rd_chk("R1 ien", 3'd2, 8'h00);
    rd_chk("R1 count", 3'd3, 8'h00);
    rd_chk("R1 limit hi", 3'd5, 8'hFF);
    rd_chk("R1 limit lo", 3'd6, 8'hFF);
    chk("R1 irq", 8'(irq_o), 8'h00);
  endtask

  task automatic t_basic();
    wr(3'd5, 8'h00); wr(3'd6, 8'd10);
    wr(3'd2, 8'h20);
    wr(3'd0, 8'h01);
    seg(0, 20); seg(1, 5); seg(0, 3); seg(1, 200); seg(0, 15);
    rd_chk("R2 R3 R4 count", 3'd3, 8'd5);
    rd_chk("R6 status after packet", 3'd1, 8'hA0);
    chk("R7 irq on pe", 8'(irq_o), 8'h01);
    wr(3'd1, 8'hFF);
    rd_chk("R6 w1c clears", 3'd1, 8'h00);
    chk("R7 irq low", 8'(irq_o), 8'h00);
    rd_chk("R2 pulse 5", 3'd4, 8'h85);
    rd_chk("R2 space 3", 3'd4, 8'h03);
    rd_chk("R3 full chunk", 3'd4, 8'hFF);
    rd_chk("R3 remainder", 3'd4, 8'hC9);
    rd_chk("R4 final space", 3'd4, 8'h0A);
    rd_chk("R8 empty after pops", 3'd3, 8'd0);
    seg(0, 30);
    rd_chk("R4 idle after pe", 3'd3, 8'd0);
  endtask

  task automatic t_invert();
    clean();
    ir_i = 1'b1;
    wr(3'd0, 8'h03);
    seg(1, 10); seg(0, 4); seg(1, 12);
    rd_chk("R5 count", 3'd3, 8'd2);
    rd_chk("R5 low is pulse", 3'd4, 8'h84);
    rd_chk("R5 high is space", 3'd4, 8'h0A);
    wr(3'd0, 8'h00);
    ir_i = 1'b0;
  endtask

  task automatic t_trigger();
    clean();
    wr(3'd0, 8'h01);
    for (int i = 0; i < 4; i++) begin
      seg(1, 1); seg(0, 1);
    end
    seg(1, 1); seg(0, 12);
    rd_chk("R9 ten bytes", 3'd3, 8'd10);
    rd_chk("R9 trig 8 reached", 3'd1, 8'hE0);
    wr(3'd1, 8'h40);
    rd_chk("R6 rtr resets while above level", 3'd1, 8'hE0);
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h40);
    rd_chk("R9 trig 16 not reached", 3'd1, 8'hA0);
    rd_chk("R8 first of order", 3'd4, 8'h81);
    rd_chk("R8 second of order", 3'd4, 8'h01);
    wr(3'd0, 8'h09);
    rd_chk("R11 flush empties", 3'd3, 8'd0);
    rd_chk("R11 ctrl bits kept", 3'd0, 8'h01);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_overrun();
    clean();
    wr(3'd5, 8'h03); wr(3'd6, 8'hE8);
    rd_chk("R4 limit hi readback", 3'd5, 8'h03);
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 20; i++) begin
      seg(1, 2); seg(0, 2);
    end
    seg(0, 3);
    rd_chk("R10 count saturates", 3'd3, 8'd32);
    rd_chk("R10 ovr and rdr", 3'd1, 8'hD0);
    chk("R7 irq on ovr", 8'(irq_o), 8'h01);
    rd_chk("R10 oldest kept", 3'd4, 8'h82);
    rd_chk("R10 second kept", 3'd4, 8'h02);
    wr(3'd0, 8'h00);
    clean();
    wr(3'd5, 8'h00); wr(3'd6, 8'd10);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_disable();
    clean();
    wr(3'd0, 8'h00);
    seg(1, 5); seg(0, 20);
    rd_chk("R12 no bytes", 3'd3, 8'd0);
    rd_chk("R12 no status", 3'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_invert();
    t_trigger();
    t_overrun();
    t_disable();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule